// File: doc/BRIEF.md
# Chunked Sequential DMA Read Splitter

The block takes one read job, a start address and a total byte count, and breaks it into a series of read requests toward a memory port. Each request covers at most a fixed maximum chunk of bytes, 4096 by default. Only one chunk is ever in flight: the next request goes out only after the last data beat of the previous chunk has returned.

After each chunk completes, the block moves two values forward by the chunk length: its running byte offset into the job and the address it will read next. Each returned data beat is passed downstream one cycle later, together with its byte offset into the destination buffer, so that a consumer can place the data without tracking the job itself.

When the offset reaches the total, the block raises a single completion. The completion carries the start address, rebuilt from the current address minus the offset, and the total length. A job of zero bytes completes at once and issues no reads.

Top module: `dma_chunk_splitter`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `busy`=0, `rd_valid`=0, `done_valid`=0, `out_valid`=0.
- R2: A job accepted with a non-zero length presents its first read in the cycle after acceptance, with `rd_addr` equal to the start address and `rd_len` equal to min(total, MAX_CHUNK).
- R3: While `rd_valid` is high and `rd_ready` is low, the request stays asserted with `rd_addr` and `rd_len` unchanged.
- R4: The cycle after a beat with `rsp_last`=1 ends a chunk and the offset is still below the total, the next read is presented. Its address is the previous address plus the previous length, and its length is min(total - offset, MAX_CHUNK).
- R5: Between a read handshake and the last beat of that chunk, `rd_valid` stays low.
- R6: The cycle after the last beat of the final chunk, `done_valid` is high for exactly one cycle, with `done_addr` equal to the start address and `done_len` equal to the total.
- R7: A job with total length 0 raises `done_valid` in the cycle after acceptance, with the start address and length 0, and issues no read.
- R8: `busy` is high, and `req_ready` low, from the cycle after acceptance until the cycle after the completion pulse. A `req_valid` seen while busy is ignored and does not alter the completion values.
- R9: Each beat accepted while a chunk is outstanding appears on `out_valid`/`out_data` one cycle later. `out_offset` equals the chunk's offset in the job plus BEAT_BYTES times the beat's index within the chunk.
- R10: Beats presented while no chunk is outstanding, including beats that carry `rsp_last`, are dropped. They produce no `out_valid` and do not end a chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Job request strobe |
| req_ready | output | 1 | Block idle and able to take a job |
| req_addr | input | ADDR_W | Job start address |
| req_len | input | LEN_W | Job total length in bytes |
| busy | output | 1 | Job in progress |
| rd_valid | output | 1 | Chunk read request valid |
| rd_ready | input | 1 | Memory port accepts the chunk request |
| rd_addr | output | ADDR_W | Chunk start address |
| rd_len | output | CHUNK_W | Chunk length in bytes |
| rsp_valid | input | 1 | Returned data beat valid |
| rsp_last | input | 1 | Beat is the last of its chunk |
| rsp_data | input | DATA_W | Returned data beat |
| out_valid | output | 1 | Forwarded beat valid |
| out_data | output | DATA_W | Forwarded beat data |
| out_offset | output | LEN_W | Byte offset of the beat in the destination |
| done_valid | output | 1 | One-cycle job completion |
| done_addr | output | ADDR_W | Start address of the completed job |
| done_len | output | LEN_W | Total length of the completed job |

## Verification
Every result of the block is one register stage from the event that causes it. The first read follows acceptance by one cycle. Forwarded beats follow their input beat by one cycle. The next read, or the completion, follows the last beat of a chunk by one cycle, and a zero-length completion follows acceptance by one cycle. The bench drives inputs on falling edges and reads outputs on the next falling edge, so each check lands in the first cycle where the result is due. It also checks the cycles in between, for held requests, silent read ports and dropped beats.

// File: rtl/chunk_split_pkg.sv
package chunk_split_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2,
        SEQ_DONE  = 2'd3
    } seq_state_e;

    localparam int unsigned DEFAULT_MAX_CHUNK = 4096;

endpackage

// File: rtl/chunk_sizer.sv
module chunk_sizer #(
    parameter int unsigned LEN_W     = 20,
    parameter int unsigned MAX_CHUNK = 4096,
    localparam int unsigned CHUNK_W  = $clog2(MAX_CHUNK + 1)
) (
    input  logic [LEN_W-1:0]   total,
    input  logic [LEN_W-1:0]   offset,
    output logic [CHUNK_W-1:0] chunk_len
);

    localparam bit          IS_POW2 = ((MAX_CHUNK & (MAX_CHUNK - 1)) == 0);
    localparam int unsigned LOG2    = $clog2(MAX_CHUNK);

    logic [LEN_W-1:0] remaining;

    always_comb begin
        remaining = total - offset;
    end

    generate
        if (IS_POW2) begin : g_pow2
            // A power-of-two limit only needs the high bits OR-reduced
            logic over;
            always_comb begin
                over      = |remaining[LEN_W-1:LOG2];
                chunk_len = over ? CHUNK_W'(MAX_CHUNK)
                                 : {1'b0, remaining[LOG2-1:0]};
            end
        end else begin : g_cmp
            always_comb begin
                if (remaining > LEN_W'(MAX_CHUNK)) begin
                    chunk_len = CHUNK_W'(MAX_CHUNK);
                end else begin
                    chunk_len = remaining[CHUNK_W-1:0];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/chunk_sequencer.sv
module chunk_sequencer
    import chunk_split_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned LEN_W      = 20,
    parameter int unsigned MAX_CHUNK  = DEFAULT_MAX_CHUNK,
    parameter int unsigned BEAT_BYTES = 8,
    localparam int unsigned CHUNK_W   = $clog2(MAX_CHUNK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              req_ready,
    output logic              busy,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [CHUNK_W-1:0] rd_len,
    input  logic              rsp_valid,
    input  logic              rsp_last,
    output logic              beat_take,
    output logic [LEN_W-1:0]  beat_offset,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_addr,
    output logic [LEN_W-1:0]  done_len
);

    typedef struct packed {
        seq_state_e         st;
        logic [ADDR_W-1:0]  cur_addr;
        logic [LEN_W-1:0]   total;
        logic [LEN_W-1:0]   offset;
        logic [CHUNK_W-1:0] clen;
        logic [CHUNK_W-1:0] intra;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [LEN_W-1:0]   sz_total_d;
    logic [LEN_W-1:0]   sz_off_d;
    logic [CHUNK_W-1:0] sz_len;
    logic [LEN_W-1:0]   next_off_d;

    // Sizer inputs: a fresh job starts at offset 0, otherwise the
    // offset just past the current chunk
    always_comb begin
        next_off_d = seq_q.offset + LEN_W'(seq_q.clen);
        if (seq_q.st == SEQ_IDLE) begin
            sz_total_d = req_len;
            sz_off_d   = '0;
        end else begin
            sz_total_d = seq_q.total;
            sz_off_d   = next_off_d;
        end
    end

    chunk_sizer #(
        .LEN_W     (LEN_W),
        .MAX_CHUNK (MAX_CHUNK)
    ) u_sizer (
        .total     (sz_total_d),
        .offset    (sz_off_d),
        .chunk_len (sz_len)
    );

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (req_valid) begin
                    seq_d.cur_addr = req_addr;
                    seq_d.total    = req_len;
                    seq_d.offset   = '0;
                    seq_d.intra    = '0;
                    seq_d.clen     = sz_len;
                    seq_d.st       = (req_len == '0) ? SEQ_DONE : SEQ_ISSUE;
                end
            end
            SEQ_ISSUE: begin
                if (rd_ready) begin
                    seq_d.st    = SEQ_WAIT;
                    seq_d.intra = '0;
                end
            end
            SEQ_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_last) begin
                        seq_d.offset   = next_off_d;
                        seq_d.cur_addr = seq_q.cur_addr + ADDR_W'(seq_q.clen);
                        seq_d.intra    = '0;
                        seq_d.clen     = sz_len;
                        seq_d.st       = (next_off_d < seq_q.total) ? SEQ_ISSUE
                                                                     : SEQ_DONE;
                    end else begin
                        seq_d.intra = seq_q.intra + CHUNK_W'(BEAT_BYTES);
                    end
                end
            end
            SEQ_DONE: begin
                seq_d.st = SEQ_IDLE;
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        req_ready   = (seq_q.st == SEQ_IDLE);
        busy        = (seq_q.st != SEQ_IDLE);
        rd_valid    = (seq_q.st == SEQ_ISSUE);
        rd_addr     = seq_q.cur_addr;
        rd_len      = seq_q.clen;
        beat_take   = (seq_q.st == SEQ_WAIT) && rsp_valid;
        beat_offset = seq_q.offset + LEN_W'(seq_q.intra);
        done_valid  = (seq_q.st == SEQ_DONE);
        done_addr   = seq_q.cur_addr - ADDR_W'(seq_q.offset);
        done_len    = seq_q.total;
    end

    AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_len != '0) && (rd_len <= CHUNK_W'(MAX_CHUNK))); // R2

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_len)); // R3

    AST_OFFSET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> seq_q.offset <= seq_q.total); // R4

    AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ready |=> !rd_valid); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R6

    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_len == '0) |=> done_valid && !rd_valid); // R7

endmodule

// File: rtl/beat_tagger.sv
module beat_tagger #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LEN_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [DATA_W-1:0] data_in,
    input  logic [LEN_W-1:0]  offset_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [LEN_W-1:0]  out_offset
);

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
        logic [LEN_W-1:0]  off;
    } tag_t;

    tag_t tag_d, tag_q;

    always_comb begin
        tag_d     = tag_q;
        tag_d.vld = take;
        if (take) begin
            tag_d.data = data_in;
            tag_d.off  = offset_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else begin
            tag_q <= tag_d;
        end
    end

    always_comb begin
        out_valid  = tag_q.vld;
        out_data   = tag_q.data;
        out_offset = tag_q.off;
    end

    AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(out_data) && $stable(out_offset)); // R9

endmodule

// File: rtl/dma_chunk_splitter.sv
module dma_chunk_splitter
    import chunk_split_pkg::*;
#(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned LEN_W     = 20,
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned MAX_CHUNK = DEFAULT_MAX_CHUNK,
    localparam int unsigned CHUNK_W    = $clog2(MAX_CHUNK + 1),
    localparam int unsigned BEAT_BYTES = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [LEN_W-1:0]   req_len,
    output logic               busy,
    output logic               rd_valid,
    input  logic               rd_ready,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic [CHUNK_W-1:0] rd_len,
    input  logic               rsp_valid,
    input  logic               rsp_last,
    input  logic [DATA_W-1:0]  rsp_data,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_data,
    output logic [LEN_W-1:0]   out_offset,
    output logic               done_valid,
    output logic [ADDR_W-1:0]  done_addr,
    output logic [LEN_W-1:0]   done_len
);

    logic             beat_take;
    logic [LEN_W-1:0] beat_offset;

    chunk_sequencer #(
        .ADDR_W     (ADDR_W),
        .LEN_W      (LEN_W),
        .MAX_CHUNK  (MAX_CHUNK),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_len     (req_len),
        .req_ready   (req_ready),
        .busy        (busy),
        .rd_valid    (rd_valid),
        .rd_ready    (rd_ready),
        .rd_addr     (rd_addr),
        .rd_len      (rd_len),
        .rsp_valid   (rsp_valid),
        .rsp_last    (rsp_last),
        .beat_take   (beat_take),
        .beat_offset (beat_offset),
        .done_valid  (done_valid),
        .done_addr   (done_addr),
        .done_len    (done_len)
    );

    beat_tagger #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_tag (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (beat_take),
        .data_in    (rsp_data),
        .offset_in  (beat_offset),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_offset (out_offset)
    );

    AST_BEAT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(rsp_valid) && $past(busy)); // R9

    AST_IDLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !out_valid); // R10

    AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done_valid)); // R8

    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> $stable(done_len) || done_valid); // R8

endmodule

// File: tb/dma_chunk_splitter_test.sv
`timescale 1ns/1ps
module dma_chunk_splitter_test;

    localparam int unsigned ADDR_W    = 32;
    localparam int unsigned LEN_W     = 20;
    localparam int unsigned DATA_W    = 64;
    localparam int unsigned MAX_CHUNK = 4096;
    localparam int unsigned CHUNK_W   = $clog2(MAX_CHUNK + 1);
    localparam int unsigned BB        = DATA_W / 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic [LEN_W-1:0]   req_len = '0;
    logic               busy;
    logic               rd_valid;
    logic               rd_ready = 1'b0;
    logic [ADDR_W-1:0]  rd_addr;
    logic [CHUNK_W-1:0] rd_len;
    logic               rsp_valid = 1'b0;
    logic               rsp_last = 1'b0;
    logic [DATA_W-1:0]  rsp_data = '0;
    logic               out_valid;
    logic [DATA_W-1:0]  out_data;
    logic [LEN_W-1:0]   out_offset;
    logic               done_valid;
    logic [ADDR_W-1:0]  done_addr;
    logic [LEN_W-1:0]   done_len;

    int unsigned checks = 0;
    int unsigned errors = 0;
    int unsigned cycles = 0;

    always #2.5 clk = ~clk;

    dma_chunk_splitter #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .MAX_CHUNK(MAX_CHUNK)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .busy(busy),
        .rd_valid(rd_valid), .rd_ready(rd_ready),
        .rd_addr(rd_addr), .rd_len(rd_len),
        .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_data(rsp_data),
        .out_valid(out_valid), .out_data(out_data), .out_offset(out_offset),
        .done_valid(done_valid), .done_addr(done_addr), .done_len(done_len)
    );

    function automatic int unsigned exp_chunk(input int unsigned total,
                                              input int unsigned off);
        int unsigned rem = total - off;
        return (rem > MAX_CHUNK) ? MAX_CHUNK : rem;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            finish_run();
        end
    end

    task automatic run_txn(input logic [ADDR_W-1:0] a, input int unsigned len);
        int unsigned off = 0;
        int unsigned clen;
        int unsigned nb;
        int unsigned stall;
        logic [DATA_W-1:0] d;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready before job", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_addr = a; req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1 && req_ready == 1'b0, "R8 busy after accept", 64'(busy), 64'd1);
        if (len == 0) begin
            chk(done_valid == 1'b1, "R7 zero-length done", 64'(done_valid), 64'd1);
            chk(done_addr == a && done_len == '0, "R7 zero-length values", 64'(done_addr), 64'(a));
            chk(rd_valid == 1'b0, "R7 no read issued", 64'(rd_valid), 64'd0);
            @(negedge clk);
            chk(done_valid == 1'b0 && busy == 1'b0, "R7 back to idle", 64'(busy), 64'd0);
            return;
        end
        while (off < len) begin
            clen = exp_chunk(len, off);
            chk(rd_valid == 1'b1, off == 0 ? "R2 first read valid" : "R4 next read valid",
                64'(rd_valid), 64'd1);
            chk(rd_addr == a + ADDR_W'(off), off == 0 ? "R2 first addr" : "R4 next addr",
                64'(rd_addr), 64'(a + ADDR_W'(off)));
            chk(rd_len == CHUNK_W'(clen), off == 0 ? "R2 first len" : "R4 next len",
                64'(rd_len), 64'(clen));
            stall = $urandom % 4;
            for (int s = 0; s < int'(stall); s++) begin
                rsp_valid = $urandom % 2 == 0; rsp_last = 1'b1;
                rsp_data = {$urandom, $urandom};
                req_valid = 1'b1; req_addr = ~a; req_len = 20'd5;
                @(negedge clk);
                chk(rd_valid && rd_addr == a + ADDR_W'(off) && rd_len == CHUNK_W'(clen),
                    "R3 request held", 64'(rd_addr), 64'(a + ADDR_W'(off)));
                chk(out_valid == 1'b0, "R10 stray beat dropped", 64'(out_valid), 64'd0);
            end
            rsp_valid = 1'b0; rsp_last = 1'b0; req_valid = 1'b0;
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
            chk(rd_valid == 1'b0, "R5 no read while outstanding", 64'(rd_valid), 64'd0);
            nb = (clen + BB - 1) / BB;
            for (int b = 0; b < int'(nb); b++) begin
                if ($urandom % 3 == 0) begin
                    @(negedge clk);
                    chk(rd_valid == 1'b0, "R5 gap no read", 64'(rd_valid), 64'd0);
                    chk(out_valid == 1'b0, "R9 no beat in gap", 64'(out_valid), 64'd0);
                end
                d = {$urandom, $urandom};
                rsp_valid = 1'b1; rsp_data = d; rsp_last = (b == int'(nb) - 1);
                @(negedge clk);
                rsp_valid = 1'b0; rsp_last = 1'b0;
                chk(out_valid == 1'b1 && out_data == d, "R9 beat forwarded", out_data, d);
                chk(out_offset == LEN_W'(off + BB * b), "R9 beat offset",
                    64'(out_offset), 64'(off + BB * b));
                if (b != int'(nb) - 1) begin
                    chk(rd_valid == 1'b0, "R5 mid-chunk no read", 64'(rd_valid), 64'd0);
                end
            end
            off += clen;
        end
        chk(done_valid == 1'b1, "R6 done raised", 64'(done_valid), 64'd1);
        chk(done_addr == a, "R6 done addr", 64'(done_addr), 64'(a));
        chk(done_len == LEN_W'(len), "R6 done len", 64'(done_len), 64'(len));
        chk(rd_valid == 1'b0, "R6 no read at done", 64'(rd_valid), 64'd0);
        @(negedge clk);
        chk(done_valid == 1'b0, "R6 single pulse", 64'(done_valid), 64'd0);
        chk(busy == 1'b0 && req_ready == 1'b1, "R8 idle after done", 64'(busy), 64'd0);
    endtask

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h5eed_c0de);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && busy == 1'b0, "R1 reset idle", 64'(busy), 64'd0);
        chk(rd_valid == 1'b0 && done_valid == 1'b0 && out_valid == 1'b0,
            "R1 reset outputs", 64'(rd_valid), 64'd0);
        // R10: beats with last while idle are dropped
        rsp_valid = 1'b1; rsp_last = 1'b1; rsp_data = 64'h1234;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_last = 1'b0;
        chk(out_valid == 1'b0 && busy == 1'b0, "R10 idle beat dropped", 64'(out_valid), 64'd0);
        // directed corners
        run_txn(32'h0000_1000, 0);
        run_txn(32'h0000_2003, 1);
        run_txn(32'h1000_0000, 8);
        run_txn(32'h2000_0000, 4096);
        run_txn(32'h3000_0010, 4097);
        run_txn(32'h4000_0000, 8192);
        run_txn(32'hFFFF_F000, 8200);
        // random jobs
        for (int t = 0; t < 10; t++) begin
            run_txn($urandom, (t % 4 == 3) ? 0 : ($urandom % 12000));
        end
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule